// File: doc/BRIEF.md
# Dual-Edge Card Data Serializer

This block turns a stream of transmit bytes into per-clock lane values for a memory-card data bus. It handles 1-, 4- and 8-line bus widths, in either single-edge or dual-data-rate timing. For each card clock cycle it presents two half-cycle values, one for the rising edge and one for the falling edge. A later pad stage picks between them and gates the card clock. The CRC bytes of a block arrive from upstream as ordinary payload. CRC generation, the receive path and pad clocking belong to other blocks.

A frame opens when the first byte is offered while the block is idle. A full-cycle start bit goes out first, then the payload, then a full-cycle end bit. After that the block releases the lines for a fixed full-cycle window in which the card returns its CRC status. In dual-data-rate mode, even-indexed bytes (counting from 0) ride the rising phase and odd-indexed bytes ride the falling phase. The framing bits stay full-cycle. Dual-rate timing is used only when the clock divider ratio is even and nonzero. Otherwise the block falls back to single-edge timing.

Width, rate mode and divider are taken when the frame opens. Bytes come in over a valid/ready handshake with a last-byte marker. If the upstream source cannot keep up, the block asks the pad stage to stop the card clock rather than sending filler.

Top module: `cdtx_ddr_serializer`

## Requirements
- R1: After reset, and whenever idle, all lane phase values are 1, `lane_oe` is 0, `clk_run` and `crc_win` are 0, and `in_ready` is 1.
- R2: `cfg_width` selects the bus: 00 drives lane 0 with one bit per cycle, most significant bit first. 01 drives lanes 3..0 with one nibble per cycle, high nibble first. 10 drives lanes 7..0 with the whole byte. 11 behaves as 00. During a frame `lane_oe` is 0x01, 0x0F or 0xFF to match, and unused lanes carry 1.
- R3: The first clocked cycle of a frame is a start bit: 0 on every active lane in both phases.
- R4: In single-edge mode the rising and falling phase values are equal in every cycle.
- R5: In dual-rate mode each payload cycle carries the current slot of byte 2k in the rising phase and the same slot of byte 2k+1 in the falling phase.
- R6: Dual-rate mode takes effect only if `cfg_ddr` is 1 and `cfg_div` is even and nonzero. Otherwise the frame is sent single-edge.
- R7: `in_ready` is low while a byte still has slots left to shift. It is high in the byte's final slot, so that a continuous source at widths 1 and 4 (and at width 8 single-edge) sees no clock-stopped cycle.
- R8: The cycle after the last payload slot is an end bit: all ones in both phases, with the lanes still enabled.
- R9: After the end bit, exactly `CRCS_CYC` cycles have `crc_win`=1, `lane_oe`=0 and `clk_run`=1. The block is then idle again.
- R10: In dual-rate mode, when the last byte has an even index, it is sent alone in the rising phase and the falling phase holds all ones.
- R11: When no byte is available for the next slot, the block inserts cycles with `clk_run`=0 and all lane values at 1. It resumes with the next byte and loses no data.
- R12: Width, rate mode and divider are sampled when the frame opens. Changes during the frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one card clock cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Bus width code (00 x1, 01 x4, 10 x8, 11 x1) |
| cfg_ddr | input | 1 | Dual-data-rate request |
| cfg_div | input | DIV_W | Card clock divider ratio |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Byte taken at this edge when valid is high |
| lane_rise | output | 8 | Lane values for the rising half-cycle |
| lane_fall | output | 8 | Lane values for the falling half-cycle |
| lane_oe | output | 8 | Per-lane drive enable |
| clk_run | output | 1 | Card clock should pulse this cycle |
| crc_win | output | 1 | CRC status window, lines released |

## Verification
The shift of a byte's final slot can fall in the same cycle as the load of the next byte. In dual-rate mode, that cycle also combines the buffered even byte with the incoming odd byte. The bench provokes this by holding `in_valid` high across whole frames at every width. It judges the result by comparing the recorded clocked cycles against a sequence built from the requirements, and by counting clock-stopped cycles against the exact number each case allows. Separate cases starve the source, end a dual-rate frame on an even byte, and change configuration mid-frame.

// File: rtl/cdtx_pkg.sv
package cdtx_pkg;

  localparam int LANE_N = 8;
  localparam int BYTE_W = 8;
  localparam int SLOT_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_END   = 3'd3,
    ST_CRCW  = 3'd4
  } fr_state_e;

  localparam logic [1:0] WM_X1  = 2'b00;
  localparam logic [1:0] WM_X4  = 2'b01;
  localparam logic [1:0] WM_X8  = 2'b10;

  function automatic logic [LANE_N-1:0] lane_mask(input logic [1:0] wm);
    case (wm)
      WM_X4:   lane_mask = 8'h0F;
      WM_X8:   lane_mask = 8'hFF;
      default: lane_mask = 8'h01;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] slot_max(input logic [1:0] wm);
    case (wm)
      WM_X4:   slot_max = 3'd1;
      WM_X8:   slot_max = 3'd0;
      default: slot_max = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/cdtx_slicer.sv
module cdtx_slicer
  import cdtx_pkg::*;
(
  input  logic [1:0]        width,
  input  logic [BYTE_W-1:0] octet,
  input  logic [SLOT_W-1:0] slot,
  output logic [LANE_N-1:0] lanes
);

  always_comb begin
    lanes = '1;
    case (width)
      WM_X8: lanes = octet;
      WM_X4: lanes[3:0] = slot[0] ? octet[3:0] : octet[7:4];
      default: lanes[0] = octet[SLOT_W'(7) - slot];
    endcase
  end

endmodule

// File: rtl/cdtx_framer.sv
module cdtx_framer
  import cdtx_pkg::*;
#(
  parameter int CRCS_CYC = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  logic      drain_next,
  output fr_state_e st
);

  localparam int CW = (CRCS_CYC > 1) ? $clog2(CRCS_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CRCS_CYC - 1);

  fr_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (st_q)
      ST_IDLE:  if (in_valid) st_d = ST_START;
      ST_START: st_d = ST_DATA;
      ST_DATA:  if (drain_next) st_d = ST_END;
      ST_END: begin
        st_d   = ST_CRCW;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      ST_CRCW: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_LAST) st_d = ST_IDLE;
        else                   cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign st = st_q;

endmodule

// File: rtl/cdtx_feed.sv
module cdtx_feed
  import cdtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fr_state_e         st,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_ddr_eff,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic [1:0]        mode_width,
  output logic              mode_ddr,
  output logic [BYTE_W-1:0] rise_byte,
  output logic [BYTE_W-1:0] fall_byte,
  output logic [SLOT_W-1:0] slot,
  output logic              sh_full,
  output logic              drain_next
);

  logic [1:0]        wm_q, wm_d;
  logic              ddr_q, ddr_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              hv_q, hv_d;
  logic              hl_q, hl_d;
  logic [BYTE_W-1:0] rb_q, rb_d, fb_q, fb_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              shv_q, shv_d;
  logic              seen_q, seen_d;

  logic is_idle, is_act, shifting, fin, free, take;

  always_comb begin
    is_idle  = (st == ST_IDLE);
    is_act   = (st == ST_START) || (st == ST_DATA);
    shifting = (st == ST_DATA) && shv_q;
    fin      = shifting && (slot_q == slot_max(wm_q));
    free     = !shv_q || fin;
    if (is_idle)                 in_ready = 1'b1;
    else if (is_act && !seen_q)  in_ready = ddr_q ? (!hv_q || free) : free;
    else                         in_ready = 1'b0;
    take = in_valid && in_ready;
  end

  always_comb begin
    wm_d   = wm_q;
    ddr_d  = ddr_q;
    hold_d = hold_q;
    hv_d   = hv_q;
    hl_d   = hl_q;
    rb_d   = rb_q;
    fb_d   = fb_q;
    slot_d = slot_q;
    shv_d  = shv_q;
    seen_d = seen_q;
    if (shifting) begin
      slot_d = fin ? '0 : SLOT_W'(slot_q + 1'b1);
      if (fin) shv_d = 1'b0;
    end
    if (is_idle) begin
      hv_d   = 1'b0;
      hl_d   = 1'b0;
      shv_d  = 1'b0;
      seen_d = 1'b0;
      slot_d = '0;
      if (in_valid) begin
        wm_d   = cfg_width;
        ddr_d  = cfg_ddr_eff;
        seen_d = in_last;
        if (cfg_ddr_eff) begin
          hold_d = in_data;
          hv_d   = 1'b1;
          hl_d   = in_last;
        end else begin
          rb_d  = in_data;
          fb_d  = in_data;
          shv_d = 1'b1;
        end
      end
    end else if (is_act) begin
      if (!ddr_q) begin
        if (take) begin
          rb_d   = in_data;
          fb_d   = in_data;
          shv_d  = 1'b1;
          slot_d = '0;
          seen_d = in_last;
        end
      end else if (take && !hv_q) begin
        hold_d = in_data;
        hv_d   = 1'b1;
        hl_d   = in_last;
        seen_d = in_last;
      end else if (hv_q && free && (take || hl_q)) begin
        rb_d   = hold_q;
        fb_d   = take ? in_data : '1;
        shv_d  = 1'b1;
        slot_d = '0;
        hv_d   = 1'b0;
        if (take) seen_d = in_last;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q   <= WM_X1;
      ddr_q  <= 1'b0;
      hold_q <= '0;
      hv_q   <= 1'b0;
      hl_q   <= 1'b0;
      rb_q   <= '0;
      fb_q   <= '0;
      slot_q <= '0;
      shv_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      wm_q   <= wm_d;
      ddr_q  <= ddr_d;
      hold_q <= hold_d;
      hv_q   <= hv_d;
      hl_q   <= hl_d;
      rb_q   <= rb_d;
      fb_q   <= fb_d;
      slot_q <= slot_d;
      shv_q  <= shv_d;
      seen_q <= seen_d;
    end
  end

  assign mode_width = wm_q;
  assign mode_ddr   = ddr_q;
  assign rise_byte  = rb_q;
  assign fall_byte  = fb_q;
  assign slot       = slot_q;
  assign sh_full    = shv_q;
  assign drain_next = seen_d && !shv_d && !hv_d;

endmodule

// File: rtl/cdtx_ddr_serializer.sv
module cdtx_ddr_serializer
  import cdtx_pkg::*;
#(
  parameter int DIV_W    = 10,
  parameter int CRCS_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_ddr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic [7:0]       lane_rise,
  output logic [7:0]       lane_fall,
  output logic [7:0]       lane_oe,
  output logic             clk_run,
  output logic             crc_win
);

  localparam int PH_N = 2;

  fr_state_e         fr_st;
  logic              ddr_eff, drain_next;
  logic [1:0]        md_width;
  logic              md_ddr;
  logic [BYTE_W-1:0] rb, fb;
  logic [SLOT_W-1:0] sh_slot;
  logic              sh_vld;
  logic [LANE_N-1:0] act_mask;

  logic [PH_N-1:0][BYTE_W-1:0] ph_byte;
  logic [PH_N-1:0][LANE_N-1:0] ph_lanes;

  assign ddr_eff = cfg_ddr && (cfg_div != '0) && !cfg_div[0];

  cdtx_framer #(.CRCS_CYC(CRCS_CYC)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .drain_next (drain_next),
    .st         (fr_st)
  );

  cdtx_feed u_feed (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (fr_st),
    .cfg_width   (cfg_width),
    .cfg_ddr_eff (ddr_eff),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .mode_width  (md_width),
    .mode_ddr    (md_ddr),
    .rise_byte   (rb),
    .fall_byte   (fb),
    .slot        (sh_slot),
    .sh_full     (sh_vld),
    .drain_next  (drain_next)
  );

  assign ph_byte[0] = rb;
  assign ph_byte[1] = fb;

  for (genvar g = 0; g < PH_N; g++) begin : g_phase
    cdtx_slicer u_slicer (
      .width (md_width),
      .octet (ph_byte[g]),
      .slot  (sh_slot),
      .lanes (ph_lanes[g])
    );
  end

  always_comb begin
    act_mask  = lane_mask(md_width);
    lane_rise = '1;
    lane_fall = '1;
    lane_oe   = '0;
    clk_run   = 1'b0;
    crc_win   = 1'b0;
    case (fr_st)
      ST_START: begin
        lane_rise = ~act_mask;
        lane_fall = ~act_mask;
        lane_oe   = act_mask;
        clk_run   = 1'b1;
      end
      ST_DATA: begin
        lane_oe = act_mask;
        if (sh_vld) begin
          clk_run   = 1'b1;
          lane_rise = ph_lanes[0];
          lane_fall = md_ddr ? ph_lanes[1] : ph_lanes[0];
        end
      end
      ST_END: begin
        lane_oe = act_mask;
        clk_run = 1'b1;
      end
      ST_CRCW: begin
        crc_win = 1'b1;
        clk_run = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cdtx_ddr_serializer_chk.sv
module cdtx_ddr_serializer_chk
  import cdtx_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_ddr,
  input logic [DIV_W-1:0] cfg_div,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       lane_rise,
  input logic [7:0]       lane_fall,
  input logic [7:0]       lane_oe,
  input logic             clk_run,
  input logic             crc_win,
  input fr_state_e        st,
  input logic [1:0]       mode_width,
  input logic             mode_ddr,
  input logic             sh_full,
  input logic [SLOT_W-1:0] slot
);

  p_lane_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe == 8'h00) || (lane_oe == 8'h01) || (lane_oe == 8'h0F) || (lane_oe == 8'hFF));

  p_unused_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_rise | lane_oe) == 8'hFF) && ((lane_fall | lane_oe) == 8'hFF));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START) |-> ((lane_rise & lane_oe) == 8'h00) && (lane_oe != 8'h00));

  p_sdr_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ddr |-> (lane_rise == lane_fall));

  p_ddr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && in_valid) |=>
      (mode_ddr == ($past(cfg_ddr) && ($past(cfg_div) != '0) && !$past(cfg_div[0]))));

  p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && sh_full && !mode_ddr && slot != slot_max(mode_width)) |-> !in_ready);

  p_crc_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    crc_win |-> (lane_oe == 8'h00) && clk_run);

  p_mode_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && $past(st) != ST_IDLE) |-> ($stable(mode_width) && $stable(mode_ddr)));

endmodule

bind cdtx_ddr_serializer cdtx_ddr_serializer_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_ddr    (cfg_ddr),
  .cfg_div    (cfg_div),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .lane_rise  (lane_rise),
  .lane_fall  (lane_fall),
  .lane_oe    (lane_oe),
  .clk_run    (clk_run),
  .crc_win    (crc_win),
  .st         (fr_st),
  .mode_width (md_width),
  .mode_ddr   (md_ddr),
  .sh_full    (sh_vld),
  .slot       (sh_slot)
);

// File: tb/test_cdtx_ddr_serializer.sv
`timescale 1ns/1ps
module test_cdtx_ddr_serializer;

  localparam int DIV_W = 10;
  localparam int CRCS  = 5;
  localparam int NV    = 12;
  localparam int MAXE  = 80;

  // fields: width, ddr, div, nbytes, seed, wiggle, gap, expected stalls
  localparam int VEC [NV][8] = '{
    '{0, 0, 4, 3,  17, 0, 0, 0},
    '{1, 0, 4, 4,  51, 0, 0, 0},
    '{2, 0, 2, 5,  90, 0, 0, 0},
    '{0, 1, 2, 4,  23, 0, 0, 0},
    '{1, 1, 4, 4,  77, 0, 0, 0},
    '{2, 1, 2, 6, 140, 0, 0, 2},
    '{1, 1, 3, 3, 200, 0, 0, 0},
    '{1, 1, 2, 3,  33, 0, 0, 0},
    '{3, 0, 6, 2, 111, 0, 0, 0},
    '{1, 0, 4, 4,  60, 1, 0, 0},
    '{2, 0, 8, 5,   9, 0, 1, 3},
    '{0, 1, 0, 2,   5, 0, 0, 0}
  };

  logic             clk, rst_n;
  logic [1:0]       cfg_width;
  logic             cfg_ddr;
  logic [DIV_W-1:0] cfg_div;
  logic             in_valid, in_last, in_ready;
  logic [7:0]       in_data, lane_rise, lane_fall, lane_oe;
  logic             clk_run, crc_win;

  int errors, checks;
  bit finished;

  cdtx_ddr_serializer #(.DIV_W(DIV_W), .CRCS_CYC(CRCS)) i_cdtx_ddr_serializer (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_ddr(cfg_ddr),
    .cfg_div(cfg_div), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .lane_rise(lane_rise), .lane_fall(lane_fall),
    .lane_oe(lane_oe), .clk_run(clk_run), .crc_win(crc_win)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input int w);
    if (w == 1) return 8'h0F;
    if (w == 2) return 8'hFF;
    return 8'h01;
  endfunction

  function automatic int slots_of(input int w);
    if (w == 1) return 2;
    if (w == 2) return 1;
    return 8;
  endfunction

  // lane word for slot s of byte b, unused lanes at 1
  function automatic logic [7:0] piece(input int w, input logic [7:0] b, input int s);
    logic [7:0] t;
    t = b << (s * (8 / slots_of(w)));
    if (w == 2) return t;
    if (w == 1) return {4'hF, t[7:4]};
    return {7'h7F, t[7]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_frame(input int v);
    int w, den, dv, n, seed, wig, gap, exst;
    logic [7:0] b [8];
    logic [7:0] er [MAXE], ef [MAXE], eo [MAXE];
    logic [7:0] cr [MAXE], cf [MAXE], co [MAXE];
    int en, cn, stalls, stall_bad, crc, crc_bad, cyc, idx, gapcnt, bad, first;
    bit eff, seen_crc, done, sdr_eq;
    logic [7:0] m, o;
    string tag;
    w = VEC[v][0]; den = VEC[v][1]; dv = VEC[v][2]; n = VEC[v][3];
    seed = VEC[v][4]; wig = VEC[v][5]; gap = VEC[v][6]; exst = VEC[v][7];
    for (int i = 0; i < n; i++) b[i] = 8'((seed + i * 73 + i * i * 5) & 255);
    eff = (den != 0) && (dv != 0) && (dv % 2 == 0);
    m = mask_of(w);
    // expected clocked cycles
    en = 0;
    er[en] = ~m; ef[en] = ~m; eo[en] = m; en++;
    if (!eff) begin
      for (int i = 0; i < n; i++)
        for (int s = 0; s < slots_of(w); s++) begin
          er[en] = piece(w, b[i], s); ef[en] = er[en]; eo[en] = m; en++;
        end
    end else begin
      for (int k = 0; k < n; k += 2)
        for (int s = 0; s < slots_of(w); s++) begin
          o = (k + 1 < n) ? piece(w, b[k+1], s) : 8'hFF;
          er[en] = piece(w, b[k], s); ef[en] = o; eo[en] = m; en++;
        end
    end
    er[en] = 8'hFF; ef[en] = 8'hFF; eo[en] = m; en++;

    if (wig != 0)                   tag = "R12";
    else if (gap != 0)              tag = "R11";
    else if (eff && (n % 2 == 1))   tag = "R10";
    else if (eff)                   tag = "R5";
    else if (den != 0)              tag = "R6";
    else                            tag = "R2";

    cfg_width = 2'(w); cfg_ddr = den[0]; cfg_div = DIV_W'(dv);
    cn = 0; stalls = 0; stall_bad = 0; crc = 0; crc_bad = 0; cyc = 0;
    idx = 0; gapcnt = 0; seen_crc = 0; done = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (clk_run && lane_oe != 8'h00) begin
        if (cn < MAXE) begin cr[cn] = lane_rise; cf[cn] = lane_fall; co[cn] = lane_oe; end
        cn++;
      end
      if (!clk_run && lane_oe != 8'h00) begin
        stalls++;
        if (lane_rise != 8'hFF || lane_fall != 8'hFF) stall_bad++;
      end
      if (crc_win) begin
        crc++;
        seen_crc = 1;
        if (lane_oe != 8'h00 || !clk_run) crc_bad++;
      end else if (seen_crc) done = 1;
      if (gap != 0 && idx == 2 && gapcnt < 3) begin
        in_valid = 1'b0; gapcnt++;
      end else if (idx < n) begin
        in_valid = 1'b1; in_data = b[idx]; in_last = (idx == n - 1);
      end else begin
        in_valid = 1'b0; in_last = 1'b0;
      end
      if (in_valid && in_ready) begin
        idx++;
        if (wig != 0 && idx >= 2) begin
          cfg_width = ~cfg_width; cfg_ddr = ~cfg_ddr; cfg_div = cfg_div + 1'b1;
        end
      end
    end
    in_valid = 1'b0;

    // R3 start bit
    chk(cn > 0 && cr[0] == er[0] && cf[0] == ef[0] && co[0] == eo[0], "R3",
        $sformatf("vec%0d start bit", v), (cn > 0) ? int'(cr[0]) : -1, int'(er[0]));
    // body
    bad = 0; first = -1;
    for (int i = 1; i < en - 1; i++)
      if (i >= cn || cr[i] != er[i] || cf[i] != ef[i] || co[i] != eo[i]) begin
        bad++; if (first < 0) first = i;
      end
    chk(bad == 0 && cn == en, tag, $sformatf("vec%0d payload entry %0d (len %0d)", v, first, cn),
        (first >= 0 && first < cn) ? int'({cr[first], cf[first]}) : cn,
        (first >= 0) ? int'({er[first], ef[first]}) : en);
    // R8 end bit
    chk(cn == en && cr[cn-1] == 8'hFF && cf[cn-1] == 8'hFF && co[cn-1] == m, "R8",
        $sformatf("vec%0d end bit", v), (cn > 0 && cn <= MAXE) ? int'(cr[cn-1]) : -1, 255);
    // R4 single-edge phases equal
    if (!eff) begin
      sdr_eq = 1;
      for (int i = 0; i < cn && i < MAXE; i++) if (cr[i] != cf[i]) sdr_eq = 0;
      chk(sdr_eq, "R4", $sformatf("vec%0d rise==fall", v), int'(sdr_eq), 1);
    end
    // R9 status window, then idle
    chk(crc == CRCS && crc_bad == 0, "R9", $sformatf("vec%0d crc window cycles", v), crc, CRCS);
    chk(in_ready && lane_oe == 8'h00 && !clk_run && !crc_win, "R9",
        $sformatf("vec%0d back to idle", v), int'(lane_oe), 0);
    // R7 (no gap) or R11 (stall)
    chk(stalls == exst && stall_bad == 0, (exst == 0) ? "R7" : "R11",
        $sformatf("vec%0d clock-stopped cycles", v), stalls, exst);
  endtask

  initial begin
    errors = 0; checks = 0; finished = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    cfg_width = '0; cfg_ddr = 1'b0; cfg_div = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(lane_rise == 8'hFF && lane_fall == 8'hFF, "R1", "lanes in reset",
        int'({lane_rise, lane_fall}), 16'hFFFF);
    chk(lane_oe == 8'h00 && !clk_run && !crc_win, "R1", "oe/clk/crc in reset",
        int'({lane_oe, clk_run, crc_win}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    chk(lane_oe == 8'h00 && lane_rise == 8'hFF && !clk_run, "R1", "idle outputs",
        int'({lane_oe, lane_rise}), 8'hFF);

    for (int v = 0; v < NV; v++) run_frame(v);

    // R1 reset in the middle of a frame returns to idle
    cfg_width = 2'd0; cfg_ddr = 1'b0; cfg_div = 10'd4;
    @(negedge clk); in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(lane_oe == 8'h00 && lane_rise == 8'hFF && !clk_run, "R1", "mid-frame reset",
        int'(lane_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !crc_win, "R1", "ready after mid-frame reset", int'(in_ready), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule